// File: doc/BRIEF.md
# Pattern-Table Gray-Scale Modulator

This block turns a stream of 2-bit display pixels into a stream of 1-bit panel pixels. Each output bit depends on the pixel's density level, its position, and the frame number. The block produces four visible densities on a panel that can only show on or off. The darkest and lightest levels are fixed at off and on. Each of the two middle levels reads a bit from its own programmable pattern table. A table holds sixteen 4x4 bit matrices. The frame counter selects the matrix, and the low bits of the pixel's column and line select the bit inside it. A suitable choice of patterns therefore mixes spatial dither with modulation over time.

Software loads the two tables through a byte-wide write port that covers a 64-byte space. Table 0 fills bytes 0 to 31 and table 1 fills bytes 32 to 63. Each pattern uses two bytes: the even byte holds rows 0 and 1, and the odd byte holds rows 2 and 3. Within a byte the low nibble is the lower row, and column 0 is the least significant bit of each nibble. Pixels enter with a valid strobe. The result leaves one clock later with its own valid strobe.

Top module: `gs_modulator`

## Requirements
- R1: After reset `out_valid_o` and `out_bit_o` are 0, and every table byte is 0, so levels 1 and 2 produce 0 until a table is written.
- R2: A valid pixel with level 0 (`pix_level_i` = 2'b00) produces `out_bit_o` = 0 whatever the table contents.
- R3: A valid pixel with level 3 (`pix_level_i` = 2'b11) produces `out_bit_o` = 1 whatever the table contents.
- R4: A valid pixel with level 1 (2'b01) outputs bit (4*(y mod 2) + (x mod 4)) of table byte 2*(f mod 16) + ((y mod 4) div 2), where x is `pix_x_i`, y is `pix_y_i` and f is `frame_i`.
- R5: A valid pixel with level 2 (2'b10) uses the same bit selection from the byte at offset 32 + 2*(f mod 16) + ((y mod 4) div 2).
- R6: `out_valid_o` equals `pix_valid_i` of the previous clock, and `out_bit_o` is the result for the pixel presented in the previous clock.
- R7: When `wr_en_i` is high, `wr_data_i` is stored at byte `wr_addr_i` (6 bits). A lookup in the same cycle as the write sees the old byte, and lookups from the next cycle on see the new byte.
- R8: When `pix_valid_i` was low in the previous clock, `out_bit_o` is 0.
- R9: Only x mod 4, y mod 4 and frame mod 16 affect the result. Pixels that differ only in higher coordinate or frame bits give the same output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table byte write strobe |
| wr_addr_i | input | 6 | Table byte address |
| wr_data_i | input | 8 | Table byte data |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_level_i | input | 2 | Pixel density level |
| pix_x_i | input | X_W (10) | Pixel column |
| pix_y_i | input | Y_W (9) | Pixel line |
| frame_i | input | F_W (8) | Frame counter |
| out_valid_o | output | 1 | Output pixel valid |
| out_bit_o | output | 1 | Output panel bit |

## Verification
A corrupted table byte does not show up as a global error. It only affects pixels of one middle level, and only when their frame, line and column select that byte and bit. The bench therefore sweeps every frame phase and every 4x4 position with random table contents, so that a bad byte or a swapped nibble or bit order shows up within one cycle of the affected lookup. A write-ordering fault shows as a mismatch on the lookup issued in the same cycle as the write. A latency or valid fault shows on the very next output cycle.

// File: rtl/gs_pkg.sv
package gs_pkg;
  localparam int unsigned PAT_SIDE      = 4;
  localparam int unsigned PAT_BITS      = PAT_SIDE * PAT_SIDE;
  localparam int unsigned PAT_PER_TBL   = 16;
  localparam int unsigned TBL_CNT       = 2;
  localparam int unsigned BYTES_PER_PAT = PAT_BITS / 8;
  localparam int unsigned TBL_BYTES     = PAT_PER_TBL * BYTES_PER_PAT;
  localparam int unsigned STORE_BYTES   = TBL_CNT * TBL_BYTES;
  localparam int unsigned ADDR_W        = $clog2(STORE_BYTES);
  localparam int unsigned PAT_IDX_W     = $clog2(PAT_PER_TBL);
  localparam int unsigned POS_W         = $clog2(PAT_SIDE);

  typedef enum logic [1:0] {
    LVL_OFF  = 2'b00,
    LVL_MID0 = 2'b01,
    LVL_MID1 = 2'b10,
    LVL_ON   = 2'b11
  } level_e;

  typedef logic [PAT_BITS-1:0] pattern_t;
endpackage

// File: rtl/gs_pattern_store.sv
module gs_pattern_store
  import gs_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [7:0]           wr_data_i,
  input  logic [PAT_IDX_W-1:0] pat_idx_i,
  output pattern_t             pat_o [TBL_CNT]
);
  logic [7:0] mem_q [STORE_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STORE_BYTES; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  // read side sees the registered contents, so a same-cycle write is not visible
  for (genvar t = 0; t < TBL_CNT; t++) begin : g_tbl
    for (genvar b = 0; b < BYTES_PER_PAT; b++) begin : g_byte
      logic [ADDR_W-1:0] rd_addr;
      always_comb begin
        rd_addr = ADDR_W'(t * TBL_BYTES + b)
                + ADDR_W'(ADDR_W'(pat_idx_i) * ADDR_W'(BYTES_PER_PAT));
      end
      assign pat_o[t][b*8 +: 8] = mem_q[rd_addr];
    end
  end
endmodule

// File: rtl/gs_bit_pick.sv
module gs_bit_pick
  import gs_pkg::*;
(
  input  level_e           level_i,
  input  pattern_t         pat_i [TBL_CNT],
  input  logic [POS_W-1:0] col_i,
  input  logic [POS_W-1:0] row_i,
  output logic             bit_o
);
  logic [2*POS_W-1:0] sel;
  assign sel = {row_i, col_i};

  always_comb begin
    unique case (level_i)
      LVL_OFF:  bit_o = 1'b0;
      LVL_MID0: bit_o = pat_i[0][sel];
      LVL_MID1: bit_o = pat_i[1][sel];
      default:  bit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/gs_modulator.sv
module gs_modulator
  import gs_pkg::*;
#(
  parameter int unsigned X_W = 10,
  parameter int unsigned Y_W = 9,
  parameter int unsigned F_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic                  pix_valid_i,
  input  logic [1:0]            pix_level_i,
  input  logic [X_W-1:0]        pix_x_i,
  input  logic [Y_W-1:0]        pix_y_i,
  input  logic [F_W-1:0]        frame_i,
  output logic                  out_valid_o,
  output logic                  out_bit_o
);
  pattern_t pat [TBL_CNT];
  logic     pick_bit;
  level_e   level;

  assign level = level_e'(pix_level_i);

  gs_pattern_store u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .pat_idx_i (frame_i[PAT_IDX_W-1:0]),
    .pat_o     (pat)
  );

  gs_bit_pick u_pick (
    .level_i (level),
    .pat_i   (pat),
    .col_i   (pix_x_i[POS_W-1:0]),
    .row_i   (pix_y_i[POS_W-1:0]),
    .bit_o   (pick_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_bit_o   <= 1'b0;
    end else begin
      out_valid_o <= pix_valid_i;
      out_bit_o   <= pix_valid_i & pick_bit;
    end
  end
endmodule

// File: rtl/gs_modulator_chk.sv
module gs_modulator_chk #(
  parameter int unsigned X_W = 10,
  parameter int unsigned Y_W = 9,
  parameter int unsigned F_W = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pix_valid_i,
  input logic [1:0] pix_level_i,
  input logic       out_valid_o,
  input logic       out_bit_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_valid_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> out_valid_o == $past(pix_valid_i));

  p_lvl_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(pix_valid_i) && $past(pix_level_i) == 2'b00) |-> !out_bit_o);

  p_lvl_on_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(pix_valid_i) && $past(pix_level_i) == 2'b11) |-> out_bit_o);

  p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(pix_valid_i)) |-> !out_bit_o);

  p_bit_needs_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_bit_o |-> out_valid_o);
endmodule

bind gs_modulator gs_modulator_chk #(.X_W(X_W), .Y_W(Y_W), .F_W(F_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pix_valid_i (pix_valid_i),
  .pix_level_i (pix_level_i),
  .out_valid_o (out_valid_o),
  .out_bit_o   (out_bit_o)
);

// File: tb/gs_modulator_tb_top.sv
module gs_modulator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int X_W = 10;
  localparam int Y_W = 9;
  localparam int F_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic pix_valid = 1'b0;
  logic [1:0] pix_level = '0;
  logic [X_W-1:0] pix_x = '0;
  logic [Y_W-1:0] pix_y = '0;
  logic [F_W-1:0] frame = '0;
  logic out_valid, out_bit;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  gs_modulator dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pix_valid_i(pix_valid), .pix_level_i(pix_level),
    .pix_x_i(pix_x), .pix_y_i(pix_y), .frame_i(frame),
    .out_valid_o(out_valid), .out_bit_o(out_bit)
  );

  function automatic logic exp_bit(logic [1:0] lv, int x, int y, int f);
    int base, addr, pos;
    if (lv == 2'b00) return 1'b0;
    if (lv == 2'b11) return 1'b1;
    base = (lv == 2'b10) ? 32 : 0;
    addr = base + 2 * (f % 16) + (y % 4) / 2;
    pos  = 4 * (y % 2) + (x % 4);
    return model[addr][pos];
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cycle(logic we, int wa, int wd, logic v, logic [1:0] lv,
                       int x, int y, int f, string req);
    logic ev, eb;
    @(negedge clk);
    wr_en = we; wr_addr = 6'(wa); wr_data = 8'(wd);
    pix_valid = v; pix_level = lv;
    pix_x = X_W'(x); pix_y = Y_W'(y); frame = F_W'(f);
    ev = v;
    eb = v ? exp_bit(lv, x, y, f) : 1'b0;
    @(posedge clk);
    if (we) model[wa] = 8'(wd);
    #1;
    chk({req, " valid"}, out_valid, ev);
    chk({req, " bit"}, out_bit, eb);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 64; i++) model[i] = '0;
    #(CLK_PERIOD * 3);
    // R1 reset state
    chk("R1 rst valid", out_valid, 1'b0);
    chk("R1 rst bit", out_bit, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    // R1 cleared tables
    for (int f = 0; f < 16; f++) begin
      cycle(0, 0, 0, 1, 2'b01, f, f + 1, f, "R1 clr t0");
      cycle(0, 0, 0, 1, 2'b10, f + 2, f, f, "R1 clr t1");
    end
    // fill all bytes with ones, then R2/R3 fixed levels
    for (int a = 0; a < 64; a++) cycle(1, a, 8'hff, 0, 2'b00, 0, 0, 0, "R8 idle");
    cycle(0, 0, 0, 1, 2'b00, 3, 2, 5, "R2 off");
    for (int a = 0; a < 64; a++) cycle(1, a, 8'h00, 0, 2'b11, 1, 1, 1, "R8 idle");
    cycle(0, 0, 0, 1, 2'b11, 1, 3, 9, "R3 on");
    // R4/R5 single-bit walk
    for (int pos = 0; pos < 16; pos++) begin
      int b = (pos / 8);
      cycle(1, 2 * 7 + b, 1 << (pos % 8), 0, 2'b00, 0, 0, 0, "R7 wr");
      cycle(1, 32 + 2 * 7 + b, 1 << (pos % 8), 0, 2'b00, 0, 0, 0, "R7 wr");
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) begin
          cycle(0, 0, 0, 1, 2'b01, c, r, 7, "R4 walk");
          cycle(0, 0, 0, 1, 2'b10, c, r, 7, "R5 walk");
        end
      cycle(1, 2 * 7 + b, 0, 0, 2'b00, 0, 0, 0, "R7 wr");
      cycle(1, 32 + 2 * 7 + b, 0, 0, 2'b00, 0, 0, 0, "R7 wr");
    end
    // R7 same-cycle write and lookup: old value, then new
    cycle(1, 2 * 3, 8'h01, 1, 2'b01, 0, 0, 3, "R7 same");
    cycle(0, 0, 0, 1, 2'b01, 0, 0, 3, "R7 next");
    chk("R7 next new", out_bit, 1'b1);
    cycle(1, 2 * 3, 8'h00, 1, 2'b01, 0, 0, 3, "R7 same old");
    chk("R7 same old one", out_bit, 1'b1);
    // R9 high bits ignored
    cycle(1, 32 + 2 * 5 + 1, 8'h20, 0, 2'b00, 0, 0, 0, "R7 wr");
    cycle(0, 0, 0, 1, 2'b10, 1, 3, 5, "R9 base");
    chk("R9 base one", out_bit, 1'b1);
    cycle(0, 0, 0, 1, 2'b10, 1 + 4 * 77, 3 + 4 * 50, 5 + 16 * 9, "R9 hi");
    chk("R9 hi one", out_bit, 1'b1);
    // R8 invalid pixel with level on
    cycle(0, 0, 0, 0, 2'b11, 0, 0, 0, "R8 invalid");
    // random mix, R6 latency throughout
    for (int n = 0; n < 4000; n++) begin
      cycle(($urandom % 3) == 0, $urandom % 64, $urandom % 256,
            ($urandom % 5) != 0, 2'($urandom), $urandom % 1024,
            $urandom % 512, $urandom % 256, "R6 rnd");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule